// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes eight asynchronous external interrupt pins and turns each one into a clean, clock-domain request. Each pin first passes through a two-stage synchronizer. An optional glitch filter follows; it samples the pin at one of four selectable rates and changes its output only when three samples in a row agree. A detector then runs in one of four modes: low level, falling edge, rising edge or both edges. It keeps one request flag per pin.

A per-pin enable gates each flag before it leaves the block as a request. The enable only masks the request. It never changes the flag, so a pending request reappears as soon as the pin is enabled again. In an edge mode, the flag stays set until the interrupt acknowledge or a software clear strobe for that pin removes it. In level mode, the flag tracks the pin directly, and neither strobe can hold it or clear it.

Each pin has a six-bit configuration register, written through a simple indexed write port. Arbitration between pins and any transfer-engine logic sit downstream of this block.

Top module: `xirq_cond`

## Requirements
- R1: After reset, `flag_o` and `req_o` are all zero. Every configuration register is zero: low-level mode, filter off, full sample rate, request disabled.
- R2: When `cfg_we_i` is high at a clock edge, the register of pin `cfg_idx_i` takes `cfg_wdata_i`, with the fields laid out as bit 5 enable, bits 4:3 sample rate, bit 2 filter enable and bits 1:0 mode. The registers of all other pins keep their values.
- R3: Mode 00 (low level): `flag_o[i]` is the inverse of the synchronized pin, three clock edges after the pin changes when the filter is off. Once the pin returns high, the flag clears; acknowledge and software clear have no effect on it.
- R4: Mode 01 (falling edge): a high-to-low transition sets the flag three clock edges later. A low-to-high transition does not set it.
- R5: Mode 10 (rising edge): a low-to-high transition sets the flag three clock edges later. A high-to-low transition does not set it.
- R6: Mode 11 (both edges): either transition sets the flag.
- R7: In any edge mode, the flag holds until `ack_i[i]` or `swclr_i[i]` is high at a clock edge, which clears it at that edge.
- R8: `req_o[i]` equals `flag_o[i]` AND the pin's enable bit. Clearing or setting the enable leaves `flag_o[i]` unchanged.
- R9: With the filter on at full rate (rate 00), a low pulse lasting 2 clock cycles is rejected. A pulse lasting 3 cycles is accepted, and the edge flag appears 6 clock edges after the pin falls.
- R10: Rate codes 01, 10 and 11 sample every 8, 32 and 64 cycles. A pulse of 2 sample periods is rejected, and a pulse of 5 sample periods is accepted.
- R11: The synchronizer and filter state reset to the high (idle) level, so enabling the filter on an idle pin raises no request. The filter output changes only at a sample instant of its selected rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw external interrupt pins, idle high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 3 | Pin index of the configuration write |
| cfg_wdata_i | input | 6 | Configuration value: {enable, rate[1:0], filter enable, mode[1:0]} |
| ack_i | input | 8 | Per-pin interrupt acknowledge; clears an edge flag |
| swclr_i | input | 8 | Per-pin software clear strobe; clears an edge flag |
| flag_o | output | 8 | Per-pin request flag |
| req_o | output | 8 | Per-pin request after the enable gate |

## Verification
A corrupted detector state appears at `flag_o` within three clock edges of the next pin transition. It shows as a missing or spurious flag, or as a flag that survives an acknowledge. A wrong filter history or sample counter only appears as a pulse that is accepted or rejected against its width. That can take up to five sample periods, or 320 cycles at the slowest rate. The bench therefore probes pulse widths just below and just above the three-sample threshold at every rate. A damaged enable or configuration register appears as a mismatch between `req_o` and `flag_o` on the very next cycle.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_FALL = 2'b01,
        DET_RISE = 2'b10,
        DET_BOTH = 2'b11
    } det_mode_e;

    // bit 5 enable, 4:3 rate, 2 filter enable, 1:0 mode
    typedef struct packed {
        logic      en;
        logic [1:0] rate;
        logic      fen;
        det_mode_e mode;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);
    localparam int N_RATES = 4;

endpackage

// File: rtl/xirq_tick.sv
module xirq_tick #(
    parameter int DIV_LG1 = 3,
    parameter int DIV_LG2 = 5,
    parameter int DIV_LG3 = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    output logic [3:0] tick_o
);
    localparam int CNT_W = DIV_LG3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tk_state_t;

    tk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o[0] = 1'b1;
    assign tick_o[1] = &st_q.cnt[DIV_LG1-1:0];
    assign tick_o[2] = &st_q.cnt[DIV_LG2-1:0];
    assign tick_o[3] = &st_q.cnt[DIV_LG3-1:0];

endmodule

// File: rtl/xirq_filter.sv
module xirq_filter #(
    parameter int NSMP = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       raw_i,
    input  logic       fen_i,
    input  logic [1:0] rate_i,
    input  logic [3:0] tick_i,
    output logic       sig_o
);
    localparam int HIST_W = NSMP - 1;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic              out;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic       smp;

    always_comb begin
        st_d = st_q;
        smp  = tick_i[rate_i];
        if (smp) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], raw_i};
            if (&{st_q.hist, raw_i})        st_d.out = 1'b1;
            else if (~|{st_q.hist, raw_i})  st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end

    assign sig_o = fen_i ? st_q.out : raw_i;

    // R11
    flt_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.out) |-> $past(tick_i[rate_i]));

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      sig_i,
    input  det_mode_e mode_i,
    input  logic      ack_i,
    input  logic      clr_i,
    output logic      flag_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       rise, fall, evt;

    always_comb begin
        st_d = st_q;
        rise = sig_i & ~st_q.prev;
        fall = ~sig_i & st_q.prev;
        unique case (mode_i)
            DET_FALL: evt = fall;
            DET_RISE: evt = rise;
            DET_BOTH: evt = rise | fall;
            default:  evt = 1'b0;
        endcase
        st_d.prev = sig_i;
        if (mode_i == DET_LOW)   st_d.flag = ~sig_i;
        else if (evt)            st_d.flag = 1'b1;
        else if (ack_i || clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev: 1'b1, flag: 1'b0};
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R3
    lvl_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == DET_LOW) && sig_i |=> !flag_o || (mode_i != DET_LOW));

    // R4
    edge_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) && ($past(mode_i) != DET_LOW) |-> $past(sig_i) != $past(st_q.prev));

    // R7
    edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != DET_LOW) && (ack_i || clr_i) && !evt |=> !flag_o || (mode_i == DET_LOW));

endmodule

// File: rtl/xirq_cond.sv
module xirq_cond
    import xirq_pkg::*;
#(
    parameter int NPIN    = 8,
    parameter int SYNC_N  = 2,
    parameter int NSMP    = 3,
    parameter int DIV_LG1 = 3,
    parameter int DIV_LG2 = 5,
    parameter int DIV_LG3 = 6,
    localparam int IDX_W  = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic [NPIN-1:0]   ack_i,
    input  logic [NPIN-1:0]   swclr_i,
    output logic [NPIN-1:0]   flag_o,
    output logic [NPIN-1:0]   req_o
);
    typedef struct packed {
        pin_cfg_t [NPIN-1:0]             cfg;
        logic [SYNC_N-1:0][NPIN-1:0]     sync;
    } top_state_t;

    top_state_t      st_d, st_q;
    logic [3:0]      tick;
    logic [NPIN-1:0] flt_sig;
    logic [NPIN-1:0] flag;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin_i;
        for (int s = 1; s < SYNC_N; s++) st_d.sync[s] = st_q.sync[s-1];
        if (cfg_we_i && (32'(cfg_idx_i) < NPIN))
            st_d.cfg[cfg_idx_i] = pin_cfg_t'(cfg_wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cfg  <= '0;
            st_q.sync <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    xirq_tick #(
        .DIV_LG1(DIV_LG1), .DIV_LG2(DIV_LG2), .DIV_LG3(DIV_LG3)
    ) u_tick (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        xirq_filter #(.NSMP(NSMP)) u_flt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .raw_i  (st_q.sync[SYNC_N-1][g]),
            .fen_i  (st_q.cfg[g].fen),
            .rate_i (st_q.cfg[g].rate),
            .tick_i (tick),
            .sig_o  (flt_sig[g])
        );

        xirq_detect u_det (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sig_i  (flt_sig[g]),
            .mode_i (st_q.cfg[g].mode),
            .ack_i  (ack_i[g]),
            .clr_i  (swclr_i[g]),
            .flag_o (flag[g])
        );

        assign req_o[g] = flag[g] & st_q.cfg[g].en;
    end

    assign flag_o = flag;

endmodule

// File: tb/xirq_cond_tb.sv
module xirq_cond_tb_top;
    import xirq_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = 8'hFF;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [5:0] cfg_wdata = '0;
    logic [7:0] ack = '0;
    logic [7:0] swclr = '0;
    logic [7:0] flag;
    logic [7:0] req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xirq_cond dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
        .ack_i(ack), .swclr_i(swclr), .flag_o(flag), .req_o(req)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wcfg(input int idx, input bit en, input logic [1:0] rate,
                        input bit fen, input logic [1:0] mode);
        cfg_we    = 1'b1;
        cfg_idx   = 3'(idx);
        cfg_wdata = {en, rate, fen, mode};
        step(1);
        cfg_we    = 1'b0;
    endtask

    task automatic strobe_ack(input int p);
        ack[p] = 1'b1;
        step(1);
        ack[p] = 1'b0;
    endtask

    task automatic t_reset();
        step(2);
        chk(flag == 8'h00, "R1 flags after reset", flag, 0);
        chk(req == 8'h00, "R1 requests after reset", req, 0);
    endtask

    task automatic t_level();
        pin[0] = 1'b0;
        step(2);
        chk(flag[0] == 1'b0, "R3 level latency early", flag[0], 0);
        step(1);
        chk(flag[0] == 1'b1, "R3 level flag set", flag[0], 1);
        chk(req[0] == 1'b0, "R1 default enable off", req[0], 0);
        ack[0] = 1'b1; swclr[0] = 1'b1;
        step(1);
        ack[0] = 1'b0; swclr[0] = 1'b0;
        chk(flag[0] == 1'b1, "R3 strobes ignored while low", flag[0], 1);
        pin[0] = 1'b1;
        step(3);
        chk(flag[0] == 1'b0, "R3 level flag released", flag[0], 0);
    endtask

    task automatic t_fall();
        wcfg(1, 1'b1, 2'b00, 1'b0, DET_FALL);
        pin[1] = 1'b0; pin[2] = 1'b0;
        step(3);
        chk(flag[1] == 1'b1, "R4 falling edge sets", flag[1], 1);
        chk(flag[2] == 1'b1, "R2 unwritten pin in level mode", flag[2], 1);
        pin[1] = 1'b1; pin[2] = 1'b1;
        step(3);
        chk(flag[1] == 1'b1, "R7 edge flag holds", flag[1], 1);
        chk(flag[2] == 1'b0, "R2 unwritten pin released", flag[2], 0);
        chk(req[2] == 1'b0, "R2 unwritten pin disabled", req[2], 0);
        chk(req[1] == 1'b1, "R8 enabled request", req[1], 1);
        strobe_ack(1);
        chk(flag[1] == 1'b0, "R7 ack clears", flag[1], 0);
        pin[1] = 1'b0;
        step(3);
        strobe_ack(1);
        pin[1] = 1'b1;
        step(4);
        chk(flag[1] == 1'b0, "R4 rising ignored", flag[1], 0);
    endtask

    task automatic t_rise();
        wcfg(1, 1'b1, 2'b00, 1'b0, DET_RISE);
        pin[1] = 1'b0;
        step(4);
        chk(flag[1] == 1'b0, "R5 falling ignored", flag[1], 0);
        pin[1] = 1'b1;
        step(2);
        chk(flag[1] == 1'b0, "R5 rising latency early", flag[1], 0);
        step(1);
        chk(flag[1] == 1'b1, "R5 rising sets", flag[1], 1);
        swclr[1] = 1'b1;
        step(1);
        swclr[1] = 1'b0;
        chk(flag[1] == 1'b0, "R7 software clear", flag[1], 0);
    endtask

    task automatic t_both();
        wcfg(1, 1'b1, 2'b00, 1'b0, DET_BOTH);
        pin[1] = 1'b0;
        step(3);
        chk(flag[1] == 1'b1, "R6 falling sets", flag[1], 1);
        strobe_ack(1);
        chk(flag[1] == 1'b0, "R6 cleared", flag[1], 0);
        pin[1] = 1'b1;
        step(3);
        chk(flag[1] == 1'b1, "R6 rising sets", flag[1], 1);
    endtask

    task automatic t_enable();
        wcfg(1, 1'b0, 2'b00, 1'b0, DET_BOTH);
        chk(req[1] == 1'b0, "R8 disable masks", req[1], 0);
        chk(flag[1] == 1'b1, "R8 flag kept when disabled", flag[1], 1);
        step(3);
        chk(flag[1] == 1'b1, "R8 flag still kept", flag[1], 1);
        wcfg(1, 1'b1, 2'b00, 1'b0, DET_BOTH);
        chk(req[1] == 1'b1, "R8 re-enable shows pending", req[1], 1);
        strobe_ack(1);
        chk(req[1] == 1'b0, "R8 cleared request", req[1], 0);
    endtask

    task automatic t_filter_fast();
        wcfg(3, 1'b1, 2'b00, 1'b1, DET_FALL);
        step(10);
        chk(flag[3] == 1'b0, "R11 no request from idle filter", flag[3], 0);
        pin[3] = 1'b0;
        step(2);
        pin[3] = 1'b1;
        step(10);
        chk(flag[3] == 1'b0, "R9 two-cycle pulse rejected", flag[3], 0);
        pin[3] = 1'b0;
        step(3);
        pin[3] = 1'b1;
        step(2);
        chk(flag[3] == 1'b0, "R9 filtered latency early", flag[3], 0);
        step(1);
        chk(flag[3] == 1'b1, "R9 three-cycle pulse accepted", flag[3], 1);
        step(10);
        strobe_ack(3);
    endtask

    task automatic t_filter_slow();
        for (int r = 1; r < 4; r++) begin
            int div;
            div = (r == 1) ? 8 : ((r == 2) ? 32 : 64);
            wcfg(4, 1'b1, 2'(r), 1'b1, DET_FALL);
            step(4 * div);
            pin[4] = 1'b0;
            step(2 * div);
            pin[4] = 1'b1;
            step(6 * div + 10);
            chk(flag[4] == 1'b0, "R10 short pulse rejected", r, 0);
            pin[4] = 1'b0;
            step(5 * div);
            pin[4] = 1'b1;
            step(6 * div + 10);
            chk(flag[4] == 1'b1, "R10 long pulse accepted", r, 1);
            strobe_ack(4);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level();
        t_fall();
        t_rise();
        t_both();
        t_enable();
        t_filter_fast();
        t_filter_slow();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule